// File: doc/BRIEF.md
# Instruction Address Sequencer

This block keeps the address of the next instruction to fetch for a small 8-bit processor. The address is 16 bits wide. Once running, it moves forward by the byte count of the instruction just fetched, or it jumps to a supplied target when a branch is taken. The decode logic supplies both the count and the target.

After reset the block does not begin at a fixed address. A short sequencer reads the two-byte start vector from the lowest locations of program memory, one byte per cycle, over a byte-wide read port. It builds the address from those two bytes and loads it. It then raises `ready_o`, and from that point the strobes from the decoder take effect.

The memory read port is synchronous. A byte requested in one cycle by `mem_rd_o` and `mem_addr_o` must appear on `mem_data_i` during the following cycle. The external reset is asynchronous and active low. Inside the block it is released in step with the clock through a small synchronizer.

Top module: `prog_counter`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0000H, `ready_o` is 0 and `mem_rd_o` is 0.
- R2: After reset is released, `mem_rd_o` is asserted in exactly two cycles before `ready_o` rises, with `mem_addr_o` 0000H in the first and 0001H in the second. It is never asserted again until the next reset.
- R3: When `ready_o` first rises, `pc_o` equals the byte read from 0001H in bits 15:8 and the byte read from 0000H in bits 7:0.
- R4: With `ready_o` high, `adv_i` high and `br_i` low at a clock edge, `pc_o` after that edge equals its previous value plus the instruction length. The length is given by `len_i`: 00 means 1 byte, 01 means 2, 10 means 3 and 11 means 4.
- R5: The advance wraps modulo 2^16; for example, FFFEH advanced by 4 bytes gives 0002H.
- R6: With `ready_o` high and `br_i` high at a clock edge, `pc_o` after that edge equals `br_target_i`.
- R7: When `adv_i` and `br_i` are both high in the same cycle, the branch is taken and the length is ignored.
- R8: Before `ready_o` rises, `adv_i` and `br_i` have no effect: the only value `pc_o` takes is the assembled vector.
- R9: With `ready_o` high and both strobes low, `pc_o` holds its value.
- R10: Once high, `ready_o` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Step forward by the instruction length |
| len_i | input | 2 | Instruction length minus one |
| br_i | input | 1 | Take a branch to `br_target_i` |
| br_target_i | input | 16 | Branch destination address |
| mem_rd_o | output | 1 | Program memory read request |
| mem_addr_o | output | 16 | Program memory read address |
| mem_data_i | input | 8 | Byte returned one cycle after the request |
| pc_o | output | 16 | Address of the next instruction |
| ready_o | output | 1 | Start vector loaded; strobes are accepted |

## Verification
The assertions assume that memory returns the requested byte exactly one cycle after the request. They also assume the strobes are stable around the clock edge. The bench's memory model is a registered read that drives `mem_data_i` only from addresses requested in the previous cycle. All strobes and targets change at falling edges.

Strobes are driven throughout the vector fetch to show they are ignored. Each start vector is followed by a pseudo-random stream of advances, branches, collisions and idle cycles, and every result is predicted by a modulo-2^16 model.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_RUN   = 2'd3
  } vec_state_e;

endpackage

// File: rtl/pc_rst_sync.sv
module pc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/pc_vec_fetch.sv
module pc_vec_fetch
  import prog_counter_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ready_o
);

  localparam int VEC_BYTES = ADDR_W / BYTE_W;
  localparam int IDX_W     = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1;
  localparam int LO_W      = ADDR_W - BYTE_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_BYTES - 1);

  vec_state_e       state_q, state_d;
  logic [IDX_W-1:0] req_q, req_d;
  logic             rx_vld_q, rx_vld_d;
  logic [IDX_W-1:0] rx_idx_q, rx_idx_d;
  logic [LO_W-1:0]  asm_q, asm_d;

  always_comb begin
    state_d  = state_q;
    req_d    = req_q;
    case (state_q)
      ST_IDLE:  state_d = ST_REQ;
      ST_REQ: begin
        if (req_q == LAST_IDX) state_d = ST_DRAIN;
        else                   req_d   = req_q + 1'b1;
      end
      ST_DRAIN: state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
    rx_vld_d = (state_q == ST_REQ);
    rx_idx_d = req_q;
  end

  always_comb begin
    asm_d = asm_q;
    for (int b = 0; b < VEC_BYTES - 1; b++) begin
      if (rx_idx_q == IDX_W'(b)) asm_d[b*BYTE_W +: BYTE_W] = mem_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      req_q    <= '0;
      rx_vld_q <= 1'b0;
      rx_idx_q <= '0;
    end else begin
      state_q  <= state_d;
      req_q    <= req_d;
      rx_vld_q <= rx_vld_d;
      rx_idx_q <= rx_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        asm_q <= '0;
    else if (rx_vld_q) asm_q <= asm_d;
  end

  assign mem_rd_o   = (state_q == ST_REQ);
  assign mem_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(req_q);
  assign load_o     = rx_vld_q && (rx_idx_q == LAST_IDX);
  assign vec_o      = {mem_data_i, asm_q};
  assign ready_o    = (state_q == ST_RUN);

  // R10: ready never drops while out of reset
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R2: no memory read once running
  a_r2_no_read_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !ready_o);

  // R2: the second read directly follows the first
  a_r2_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_addr_o == ADDR_W'(VEC_BASE)) |=> mem_rd_o);

  // R3: ready rises only right after the vector load
  a_r3_load_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(load_o));

endmodule

// File: rtl/pc_step_reg.sv
module pc_step_reg #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] vec_i,
  input  logic              ready_i,
  input  logic              adv_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              br_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] step;
  logic              pc_en;

  assign step  = ADDR_W'(len_i) + ADDR_W'(1);
  assign pc_en = load_i || (ready_i && (br_i || adv_i));

  always_comb begin
    if (load_i)    pc_d = vec_i;
    else if (br_i) pc_d = target_i;
    else           pc_d = pc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R6, R7: a branch while running lands on the target
  a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && br_i) |=> (pc_o == $past(target_i)));

  // R9: idle cycles leave the counter alone
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !br_i && !adv_i) |=> $stable(pc_o));

  // R8: before ready only the vector load may change the counter
  a_r8_ignore_early: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_i && !load_i) |=> $stable(pc_o));

  // R4: an advance changes the counter by one to four bytes
  a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && adv_i && !br_i) |=>
      ((pc_o - $past(pc_o)) >= ADDR_W'(1) && (pc_o - $past(pc_o)) <= ADDR_W'(1 << LEN_W)));

endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
  parameter int ADDR_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int LEN_W      = 2,
  parameter int VEC_BASE   = 0,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              br_i,
  input  logic [ADDR_W-1:0] br_target_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ready_o
);

  logic              rst_n_int;
  logic              vec_load;
  logic [ADDR_W-1:0] vec_val;

  pc_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  pc_vec_fetch #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .VEC_BASE (VEC_BASE)
  ) fetch_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .mem_data_i (mem_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .load_o     (vec_load),
    .vec_o      (vec_val),
    .ready_o    (ready_o)
  );

  pc_step_reg #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) step_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (vec_load),
    .vec_i    (vec_val),
    .ready_i  (ready_o),
    .adv_i    (adv_i),
    .len_i    (len_i),
    .br_i     (br_i),
    .target_i (br_target_i),
    .pc_o     (pc_o)
  );

  // R1: held reset gives a clear counter and no request
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (pc_o == '0 && !ready_o && !mem_rd_o));

endmodule

// File: tb/prog_counter_tb_top.sv
`timescale 1ns/1ps
module prog_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i;
  logic [1:0]  len_i;
  logic        br_i;
  logic [15:0] br_target_i;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  logic [15:0] pc_o;
  logic        ready_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  vlo, vhi;
  logic [15:0] rd_log [4];
  int          n_rd;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  prog_counter dut_i (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .len_i(len_i), .br_i(br_i),
    .br_target_i(br_target_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .pc_o(pc_o), .ready_o(ready_o)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (a == 16'h0000)      return vlo;
    else if (a == 16'h0001) return vhi;
    else                    return 8'hEE;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o) mem_data_i <= mem_byte(mem_addr_o);
    if (rst_n && mem_rd_o) begin
      if (n_rd < 4) rd_log[n_rd] = mem_addr_o;
      n_rd = n_rd + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] next_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_vector(input logic [15:0] vec);
    logic [15:0] exp_pc;
    logic [15:0] nxt;
    int          waited;
    vlo = vec[7:0];
    vhi = vec[15:8];
    @(negedge clk);
    rst_n = 1'b0;
    adv_i = 1'b0; br_i = 1'b0; len_i = 2'd0; br_target_i = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 pc", {16'h0, pc_o}, {16'h0, 16'h0000});
    check("R1 ready", {31'h0, ready_o}, 32'h0);
    check("R1 rd", {31'h0, mem_rd_o}, 32'h0);
    n_rd = 0;
    rst_n = 1'b1;
    // R8: strobes toggled throughout the vector fetch
    waited = 0;
    while (!ready_o && waited < 20) begin
      adv_i = 1'b1; len_i = 2'd3;
      br_i = waited[0]; br_target_i = 16'h5A5A;
      @(negedge clk);
      if (!ready_o) check("R8 pc before ready", {16'h0, pc_o}, 32'h0);
      waited++;
    end
    adv_i = 1'b0; br_i = 1'b0;
    check("R10 ready rose", {31'h0, ready_o}, 32'h1);
    check("R3 vector", {16'h0, pc_o}, {16'h0, vec});
    check("R2 read count", n_rd, 2);
    check("R2 first addr", {16'h0, rd_log[0]}, 32'h0000);
    check("R2 second addr", {16'h0, rd_log[1]}, 32'h0001);
    exp_pc = vec;
    // R4, R5: every length in turn
    for (int l = 3; l >= 0; l--) begin
      adv_i = 1'b1; len_i = l[1:0];
      @(negedge clk);
      nxt = exp_pc + 16'(l + 1);
      check(nxt < exp_pc ? "R5 wrap" : "R4 advance", {16'h0, pc_o}, {16'h0, nxt});
      exp_pc = nxt;
    end
    // R4, R6, R7, R9: pseudo-random stream
    for (int k = 0; k < 400; k++) begin
      lfsr = next_lfsr(lfsr);
      adv_i = lfsr[0];
      br_i  = lfsr[1] & lfsr[2];
      len_i = lfsr[4:3];
      br_target_i = {lfsr[7:0], lfsr[15:8]};
      @(negedge clk);
      if (br_i)       nxt = br_target_i;
      else if (adv_i) nxt = exp_pc + 16'(len_i) + 16'd1;
      else            nxt = exp_pc;
      if (br_i && adv_i)    check("R7 branch wins", {16'h0, pc_o}, {16'h0, nxt});
      else if (br_i)        check("R6 branch", {16'h0, pc_o}, {16'h0, nxt});
      else if (adv_i)       check(nxt < exp_pc ? "R5 wrap" : "R4 advance", {16'h0, pc_o}, {16'h0, nxt});
      else                  check("R9 hold", {16'h0, pc_o}, {16'h0, nxt});
      check("R10 ready stays", {31'h0, ready_o}, 32'h1);
      exp_pc = nxt;
    end
    adv_i = 1'b0; br_i = 1'b0;
    check("R2 no late read", n_rd, 2);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    adv_i = 1'b0; br_i = 1'b0; len_i = 2'd0; br_target_i = 16'h0;
    n_rd = 0;
    run_vector(16'h1234);
    run_vector(16'hFFFE);
    run_vector(16'h0000);
    run_vector(16'hA5C3);
    run_vector(16'hFFFF);
    summary();
  end

endmodule